// File: doc/BRIEF.md
# Interrupt Cause Register Bank

This block collects up to 32 interrupt sources into one word-addressed register bank and drives a single level interrupt line. A source becomes pending when its hardware event input pulses high, or when software writes a 1 to the matching bit of the software-set register. Each source uses the same bit position in every register of the bank. A mask hides a pending source from the interrupt line. Software can rewrite the whole mask, or set or clear individual mask bits without a read-modify-write.

Every source also has a clear-mode bit, and software can change it at any time. With the bit at 0, software acknowledges the source by writing a 1 to it. With the bit at 1, the source is acknowledged when software reads it. The view of the pending sources after masking follows the same per-bit rule. Reads return data one cycle after the request, and each request takes one cycle.

Top module: `irq_cause_bank`

## Requirements
- R1: A high level on `evt_i[k]` at a clock edge makes pending bit k read as 1 from the next cycle onward, until it is cleared.
- R2: Offset 1 reads the pending vector. Pending bits whose clear-mode bit (offset 0) is 0 clear when written with 1. Pending bits whose clear-mode bit is 1 ignore writes and clear when offset 1 is read. A read returns the value from before the clear, and clears only bits that were 1 at that read.
- R3: Offset 2 reads pending AND NOT mask. A write of 1 to offset 2 clears write-one-to-clear bits, whether they are masked or not. A read of offset 2 clears the clear-on-read bits that it returns as 1.
- R4: Writing offset 3 sets every pending bit that is written with 1. Bits written with 0 are unchanged.
- R5: Writing offset 5 sets the mask bits that are written with 1. Writing offset 6 clears the mask bits that are written with 1. A 0 leaves a mask bit unchanged.
- R6: Writing offset 4 loads the whole mask, and offset 4 reads it back. Offset 0 is written and read back as a plain 32-bit value.
- R7: If a hardware event and a clear (written or read) reach the same pending bit at the same edge, the bit stays set.
- R8: `irq_o` is high exactly when at least one pending bit is set and unmasked (a mask bit of 1 hides the source).
- R9: After reset the clear-mode and pending registers are all zeros, the mask is all ones, and `irq_o` is low.
- R10: Offsets 3, 5 and 6 are write-only and read as zero. Offset 7 reads as zero and ignores writes.
- R11: The data for a read request appears on `rd_data` in the cycle after the request, and stays there until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 32 | Hardware event pulses, one per source |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Word offset of the register |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after the request |
| irq_o | output | 1 | Level interrupt, high while an unmasked source is pending |

## Verification
The bench drives an event into a bit at the same edge that clears it, both by a write and by a clear-on-read access. A design that gives the clear priority loses that event for good. It switches bits between the two clear modes at run time and reads each mode twice. A design that clears the wrong group leaves write-one-to-clear bits gone after a read, or leaves clear-on-read bits stuck. The bench also reads the masked view while masked clear-on-read bits are pending, which shows whether that access clears bits it did not return. It reads the write-only and unused offsets, where stale register contents would show up. A long mixed stretch of events and accesses then exposes any set/clear precedence slip in the mask logic.

// File: rtl/irq_bank_pkg.sv
`timescale 1ns/1ps
package irq_bank_pkg;

    localparam int ADDR_W = 3;

    // Word offsets; the order is part of the register contract.
    typedef enum logic [ADDR_W-1:0] {
        OFS_MODE     = 3'd0,
        OFS_PEND     = 3'd1,
        OFS_PEND_MSK = 3'd2,
        OFS_PEND_SET = 3'd3,
        OFS_MASK     = 3'd4,
        OFS_MASK_ON  = 3'd5,
        OFS_MASK_OFF = 3'd6,
        OFS_NONE     = 3'd7
    } ofs_e;

    // One-hot style strobes for a single access cycle.
    typedef struct packed {
        logic rd;
        logic mode_wr;
        logic pend_wr;
        logic pend_rd;
        logic pmsk_wr;
        logic pmsk_rd;
        logic set_wr;
        logic mask_wr;
        logic mask_on;
        logic mask_off;
        ofs_e ofs;
    } acc_t;

    function automatic acc_t decode_access(input logic valid,
                                           input logic write,
                                           input logic [ADDR_W-1:0] addr);
        acc_t a;
        logic wr;
        logic rd;
        a     = '0;
        a.ofs = ofs_e'(addr);
        wr    = valid & write;
        rd    = valid & ~write;
        a.rd  = rd;
        unique case (a.ofs)
            OFS_MODE:     a.mode_wr  = wr;
            OFS_PEND:     begin a.pend_wr = wr; a.pend_rd = rd; end
            OFS_PEND_MSK: begin a.pmsk_wr = wr; a.pmsk_rd = rd; end
            OFS_PEND_SET: a.set_wr   = wr;
            OFS_MASK:     a.mask_wr  = wr;
            OFS_MASK_ON:  a.mask_on  = wr;
            OFS_MASK_OFF: a.mask_off = wr;
            default:      ;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/irq_access_decode.sv
`timescale 1ns/1ps
module irq_access_decode
    import irq_bank_pkg::*;
(
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output acc_t              acc
);
    always_comb begin
        acc = decode_access(req_valid, req_write, req_addr);
    end
endmodule

// File: rtl/irq_ctrl_regs.sv
`timescale 1ns/1ps
module irq_ctrl_regs
    import irq_bank_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  acc_t         acc,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mode_q,
    output logic [N-1:0] mask_q
);
    localparam logic [N-1:0] MASK_RST = {N{1'b1}};

    logic [N-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        if (acc.mask_wr)  mask_d = wdata;
        if (acc.mask_on)  mask_d = mask_q | wdata;
        if (acc.mask_off) mask_d = mask_q & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            mask_q <= MASK_RST;
        end else begin
            if (acc.mode_wr) mode_q <= wdata;
            mask_q <= mask_d;
        end
    end
endmodule

// File: rtl/irq_pend_core.sv
`timescale 1ns/1ps
module irq_pend_core
    import irq_bank_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  acc_t         acc,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] mode,
    input  logic [N-1:0] mask,
    output logic [N-1:0] pend_q
);
    logic [N-1:0] clr_vec;
    logic [N-1:0] set_vec;

    always_comb begin
        clr_vec = '0;
        if (acc.pend_wr || acc.pmsk_wr) clr_vec = wdata & ~mode;
        if (acc.pend_rd)                clr_vec = pend_q & mode;
        if (acc.pmsk_rd)                clr_vec = pend_q & ~mask & mode;
        set_vec = acc.set_wr ? wdata : '0;
    end

    // One cell per source: set (event or software) wins over clear.
    for (genvar k = 0; k < N; k++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[k] <= 1'b0;
            end else if (evt[k] || set_vec[k]) begin
                pend_q[k] <= 1'b1;
            end else if (clr_vec[k]) begin
                pend_q[k] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_cause_bank.sv
`timescale 1ns/1ps
module irq_cause_bank
    import irq_bank_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      evt_i,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [N-1:0]      req_wdata,
    output logic [N-1:0]      rd_data,
    output logic              irq_o
);
    acc_t         acc;
    logic [N-1:0] mode_q;
    logic [N-1:0] mask_q;
    logic [N-1:0] pend_q;
    logic [N-1:0] visible;
    logic [N-1:0] rd_mux;

    irq_access_decode u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .acc       (acc)
    );

    irq_ctrl_regs #(.N(N)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .wdata  (req_wdata),
        .mode_q (mode_q),
        .mask_q (mask_q)
    );

    irq_pend_core #(.N(N)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .wdata  (req_wdata),
        .evt    (evt_i),
        .mode   (mode_q),
        .mask   (mask_q),
        .pend_q (pend_q)
    );

    assign visible = pend_q & ~mask_q;
    assign irq_o   = |visible;

    always_comb begin
        unique case (acc.ofs)
            OFS_MODE:     rd_mux = mode_q;
            OFS_PEND:     rd_mux = pend_q;
            OFS_PEND_MSK: rd_mux = visible;
            OFS_MASK:     rd_mux = mask_q;
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_data <= '0;
        else if (acc.rd) rd_data <= rd_mux;
    end
endmodule

// File: rtl/irq_cause_bank_chk.sv
`timescale 1ns/1ps
module irq_cause_bank_chk #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] evt_i,
    input logic         req_valid,
    input logic         req_write,
    input logic [2:0]   req_addr,
    input logic [N-1:0] req_wdata,
    input logic [N-1:0] rd_data,
    input logic         irq_o,
    input logic [N-1:0] pend_q,
    input logic [N-1:0] mask_q,
    input logic [N-1:0] mode_q
);
    // R9: state right after a reset cycle
    a_r9_reset_values: assert property (@(posedge clk)
        rst |=> (mask_q == {N{1'b1}} && pend_q == '0 && mode_q == '0 && !irq_o));

    // R1 / R7: every event bit is pending on the next cycle, whatever clears it
    a_r7_event_kept: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

    // R4: software set bits are pending next cycle
    a_r4_sw_set: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == 3'd3)
        |=> ((pend_q & $past(req_wdata)) == $past(req_wdata)));

    // R5: mask set and mask clear
    a_r5_mask_on: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == 3'd5)
        |=> ((mask_q & $past(req_wdata)) == $past(req_wdata)));
    a_r5_mask_off: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == 3'd6)
        |=> ((mask_q & $past(req_wdata)) == '0));

    // R2: a pending-vector read leaves no clear-on-read bit set unless re-raised
    a_r2_cor_read: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr == 3'd1)
        |=> ((pend_q & $past(mode_q & pend_q & ~evt_i)) == '0));

    // R10: write-only and unused offsets read as zero
    a_r10_wo_zero: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write &&
         (req_addr == 3'd3 || req_addr == 3'd5 || req_addr == 3'd6 || req_addr == 3'd7))
        |=> (rd_data == '0));

    // R8: no line without an unmasked pending source
    a_r8_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & ~mask_q) == '0) |-> !irq_o);
endmodule

bind irq_cause_bank irq_cause_bank_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt_i),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_data   (rd_data),
    .irq_o     (irq_o),
    .pend_q    (pend_q),
    .mask_q    (mask_q),
    .mode_q    (mode_q)
);

// File: tb/sim_irq_cause_bank.sv
`timescale 1ns/1ps
module sim_irq_cause_bank;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] evt_i;
    logic         req_valid;
    logic         req_write;
    logic [2:0]   req_addr;
    logic [W-1:0] req_wdata;
    logic [W-1:0] rd_data;
    logic         irq_o;

    int checks = 0;
    int errors = 0;

    // Bench-side view of the bank, built from the requirements.
    logic [W-1:0] m_mode = '0;
    logic [W-1:0] m_mask = '1;
    logic [W-1:0] m_pend = '0;

    logic [W-1:0] exp_q[$];
    string        tag_q[$];
    logic         rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    irq_cause_bank #(.N(W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt_i),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_data   (rd_data),
        .irq_o     (irq_o)
    );

    // Monitor: a read issued at an edge is compared at the following negedge (R11).
    always @(posedge clk) rd_seen <= !rst && req_valid && !req_write;

    always @(negedge clk) begin
        if (rd_seen) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R11 unexpected read data actual=%h expected=none", rd_data);
            end else begin
                logic [W-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, rd_data, e);
                end
            end
        end
    end

    // Driver: one access per cycle, expected items pushed to the scoreboard.
    task automatic op(input bit wr, input logic [2:0] a, input logic [W-1:0] d,
                      input logic [W-1:0] ev, input string tag);
        logic [W-1:0] clr;
        logic [W-1:0] set;
        logic [W-1:0] rv;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        evt_i     = ev;
        clr = '0;
        set = '0;
        if (!wr) begin
            case (a)
                3'd0:    rv = m_mode;
                3'd1:    rv = m_pend;
                3'd2:    rv = m_pend & ~m_mask;
                3'd4:    rv = m_mask;
                default: rv = '0;
            endcase
            exp_q.push_back(rv);
            tag_q.push_back(tag);
            if (a == 3'd1) clr = m_pend & m_mode;
            if (a == 3'd2) clr = m_pend & ~m_mask & m_mode;
        end else begin
            case (a)
                3'd0:    m_mode = d;
                3'd1:    clr = d & ~m_mode;
                3'd2:    clr = d & ~m_mode;
                3'd3:    set = d;
                3'd4:    m_mask = d;
                3'd5:    m_mask = m_mask | d;
                3'd6:    m_mask = m_mask & ~d;
                default: ;
            endcase
        end
        m_pend = (m_pend & ~clr) | ev | set;
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        op(1'b0, a, '0, '0, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d, input string tag);
        op(1'b1, a, d, '0, tag);
    endtask

    task automatic check_irq(input string tag);
        logic e;
        @(negedge clk);
        req_valid = 1'b0;
        evt_i     = '0;
        e = |(m_pend & ~m_mask);
        checks++;
        if (irq_o !== e) begin
            errors++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq_o, e);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; evt_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset values
        check_irq("R9 reset irq");
        rd(3'd0, "R9 reset clear-mode");
        rd(3'd1, "R9 reset pending");
        rd(3'd4, "R9 reset mask");

        // R1 hardware event, masked so no line yet
        op(1'b0, 3'd7, '0, 32'h0000_0008, "R10 unused offset read");
        rd(3'd1, "R1 event sets pending bit 3");
        check_irq("R8 masked source keeps line low");

        // R5 mask clear, R8 line rises
        wr(3'd6, 32'h0000_0008, "R5 mask off");
        check_irq("R8 unmasked source raises line");
        rd(3'd4, "R5 mask readback after clear");
        rd(3'd2, "R3 masked view");
        rd(3'd1, "R2 write-one-to-clear bit survives read");

        // R2 write-one-to-clear
        wr(3'd1, 32'h0000_0008, "R2 w1c write");
        rd(3'd1, "R2 pending after w1c");
        check_irq("R8 line drops after clear");

        // R4 software set, R10 write-only reads zero
        wr(3'd3, 32'h0000_0030, "R4 software set");
        rd(3'd1, "R4 pending after software set");
        rd(3'd3, "R10 set register reads zero");
        rd(3'd5, "R10 mask-on register reads zero");
        rd(3'd6, "R10 mask-off register reads zero");

        // R2 clear-on-read switched at run time
        wr(3'd0, 32'h0000_0010, "R6 clear-mode write");
        rd(3'd0, "R6 clear-mode readback");
        wr(3'd1, 32'h0000_0010, "R2 write ignored on clear-on-read bit");
        rd(3'd1, "R2 clear-on-read returns pre-clear value");
        rd(3'd1, "R2 clear-on-read bit gone, w1c bit kept");

        // R3 masked-view access clears by the same rule
        wr(3'd3, 32'h0000_0010, "R4 re-set bit 4");
        wr(3'd0, 32'h0000_0030, "R6 both bits clear-on-read");
        wr(3'd6, 32'h0000_0010, "R5 unmask bit 4 only");
        rd(3'd2, "R3 masked read returns bit 4");
        rd(3'd1, "R3 masked read cleared only unmasked bit");
        wr(3'd0, 32'h0000_0000, "R6 back to w1c");
        wr(3'd2, 32'h0000_0020, "R3 w1c through masked offset on masked bit");
        rd(3'd1, "R3 pending after masked-offset write");

        // R7 event wins over clear
        op(1'b1, 3'd1, 32'h0000_0100, 32'h0000_0100, "R7 event with w1c write");
        rd(3'd1, "R7 bit kept after write clash");
        wr(3'd0, 32'h0000_0100, "R6 bit 8 clear-on-read");
        op(1'b0, 3'd1, '0, 32'h0000_0100, "R7 read clash returns set bit");
        rd(3'd1, "R7 bit kept after read clash");
        rd(3'd1, "R2 bit cleared by later read");

        // R6 direct mask load and R5 mask set
        wr(3'd4, 32'h0000_0000, "R6 mask load zero");
        rd(3'd4, "R6 mask readback zero");
        wr(3'd5, 32'h0000_00F0, "R5 mask on");
        rd(3'd4, "R5 mask after set");
        wr(3'd7, 32'hFFFF_FFFF, "R10 unused write ignored");
        rd(3'd4, "R10 mask untouched by unused write");
        rd(3'd1, "R10 pending untouched by unused write");
        check_irq("R8 line after mask changes");

        // Mixed traffic
        for (int i = 0; i < 600; i++) begin
            logic [W-1:0] ev;
            logic [2:0]   a;
            bit           w;
            ev = $urandom() & $urandom() & $urandom() & $urandom();
            a  = 3'($urandom() % 8);
            w  = 1'($urandom() % 2);
            op(w, a, $urandom(), ev, "R11 mixed traffic");
            if (i % 8 == 0) check_irq("R8 mixed traffic");
        end
        rd(3'd1, "R1 final pending");
        rd(3'd4, "R5 final mask");
        check_irq("R8 final line");
        repeat (2) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11 reads outstanding actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule